// File: doc/BRIEF.md
# BT656 Field Formatter with Line Repeat

This block turns horizontally scaled 4:2:2 video lines into an 8-bit byte stream with embedded sync, intended for a 625-line, 50 field/s system at 27 MHz. Each progressive source frame of 240 lines becomes one output field with 288 active lines. The 48 extra lines come from a fixed cadence: after every five source lines, the fifth is sent a second time. Consecutive source frames leave as alternate fields, so the downstream encoder pairs them into one 576-line frame. There is no vertical filtering.

Every line starts with an end-of-active-video timing code, which is followed by horizontal blanking. A start-of-active-video code comes next, and the active region closes the line. Lines outside the active window of a field carry blanking in their active region. The formatter drives a small read port towards an upstream line buffer. A strobe at the start of each active line names the source line to replay, and per-byte read requests fetch the active bytes in Cb, Y, Cr, Y order. A repeated line reads the same buffer entry again.

Top module: `vfmt_bt656_formatter`

## Requirements
- R1: While reset is held, and right after it, `bt_byte` is 0x10 and `line_start` and `rd_en` are low. Output starts at the first byte of line 0 of a field with F=0.
- R2: A line is LINE_BYTES bytes long. Bytes 0..3 are FF 00 00 XY with H=1. Bytes LINE_BYTES-2*ACT_PIX-4 .. LINE_BYTES-2*ACT_PIX-1 are FF 00 00 XY with H=0. The last 2*ACT_PIX bytes form the active region.
- R3: XY bit 7 is 1 and bit 4 is H. Bits 3..0 are V^H, F^H, F^V and F^V^H, from bit 3 down to bit 0.
- R4: XY bit 5 (V) is 0 only on field lines VB_TOP .. VB_TOP+ACT_LINES-1, where ACT_LINES = SRC_LINES*(REP+1)/REP. A field with F=0 has FIELD0_LINES lines and a field with F=1 has FIELD1_LINES lines.
- R5: XY bit 6 (F) is 0 in the first field after reset and inverts at the start of each following field.
- R6: Bytes in horizontal blanking, and bytes in the active region of V=1 lines, are 0x80 at even line positions and 0x10 at odd ones.
- R7: In an active line, active byte n equals the `rd_data` returned for a read with `rd_addr`=n. Each read is issued with `rd_en` while the byte counter sits one position before that byte. The counter reaches byte 0's position one position after the last SAV byte. `rd_data` is taken one clock after the read.
- R8: Active line a of a field (a = 0 .. ACT_LINES-1) replays source line (a/(REP+1))*REP + min(a mod (REP+1), REP-1). This is the value of `src_line` for all of that line.
- R9: `line_start` pulses for one clock, one clock before the first EAV byte of each active line, and never during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_data | input | 8 | Byte returned by the line buffer one clock after a read |
| bt_byte | output | 8 | Formatted output byte stream |
| line_start | output | 1 | Pulse announcing the next active line |
| src_line | output | $clog2(SRC_LINES+1) | Source line to replay for the current active line |
| rd_en | output | 1 | Read request to the line buffer |
| rd_addr | output | $clog2(2*ACT_PIX) | Byte index within the source line being read |

## Verification
`bt_byte` is registered, so the byte for a counter position appears one clock after the counter reaches that position. `line_start`, `rd_en` and `rd_addr` are decoded from the counter in the same clock. Active data therefore shows up on `bt_byte` two clocks after its read request. The bench samples on the falling edge. Each sample is compared with the expected byte of stream position k, and the strobes are compared with the expectations for position k+1. The buffer model answers reads on the rising edge, which gives the single clock of read latency.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

    typedef enum logic [1:0] {
        SEG_EAV,
        SEG_HBLK,
        SEG_SAV,
        SEG_ACT
    } seg_e;

    localparam logic [7:0] FILL_CHROMA = 8'h80;
    localparam logic [7:0] FILL_LUMA   = 8'h10;
    localparam logic [7:0] TRS_FF      = 8'hFF;
    localparam logic [7:0] TRS_00      = 8'h00;

    // Fourth byte of a timing code with its protection bits
    function automatic logic [7:0] trs_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vfmt_hpos.sv
module vfmt_hpos
    import vfmt_pkg::*;
#(
    parameter  int LINE_BYTES = 1728,
    parameter  int ACT_BYTES  = 1440,
    localparam int HW         = $clog2(LINE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h,
    output logic          line_end,
    output seg_e          seg,
    output logic [1:0]    idx
);

    localparam logic [HW-1:0] H_LAST = HW'(LINE_BYTES - 1);
    localparam logic [HW-1:0] H_SAV  = HW'(LINE_BYTES - ACT_BYTES - 4);
    localparam logic [HW-1:0] H_ACT  = HW'(LINE_BYTES - ACT_BYTES);
    localparam logic [HW-1:0] H_HBLK = HW'(4);

    typedef struct packed {
        logic [HW-1:0] h;
    } hst_t;

    hst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.h == H_LAST) st_d.h = '0;
        else                  st_d.h = st_q.h + 1'b1;

        line_end = (st_q.h == H_LAST);
        h        = st_q.h;
        if (st_q.h < H_HBLK) begin
            seg = SEG_EAV;
            idx = st_q.h[1:0];
        end else if (st_q.h < H_SAV) begin
            seg = SEG_HBLK;
            idx = 2'd0;
        end else if (st_q.h < H_ACT) begin
            seg = SEG_SAV;
            idx = 2'(st_q.h - H_SAV);
        end else begin
            seg = SEG_ACT;
            idx = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (h == '0 && seg == SEG_EAV)); // R2

endmodule

// File: rtl/vfmt_vpos.sv
module vfmt_vpos #(
    parameter  int SRC_LINES    = 240,
    parameter  int REP          = 5,
    parameter  int VB_TOP       = 22,
    parameter  int FIELD0_LINES = 313,
    parameter  int FIELD1_LINES = 312,
    localparam int ACT_LINES    = SRC_LINES * (REP + 1) / REP,
    localparam int FMAX         = (FIELD0_LINES > FIELD1_LINES) ? FIELD0_LINES : FIELD1_LINES,
    localparam int VW           = $clog2(FMAX),
    localparam int SW           = $clog2(SRC_LINES + 1),
    localparam int PW           = $clog2(REP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    output logic          act,
    output logic          fld,
    output logic [SW-1:0] src
);

    localparam logic [VW-1:0] V_LAST0 = VW'(FIELD0_LINES - 1);
    localparam logic [VW-1:0] V_LAST1 = VW'(FIELD1_LINES - 1);
    localparam logic [VW-1:0] V_TOP   = VW'(VB_TOP);
    localparam logic [VW-1:0] V_END   = VW'(VB_TOP + ACT_LINES);
    localparam logic [PW-1:0] PH_MAX  = PW'(REP);
    localparam logic [SW-1:0] SRC_LIM = SW'(SRC_LINES);

    typedef struct packed {
        logic [VW-1:0] v;
        logic          f;
        logic [SW-1:0] src;
        logic [PW-1:0] ph;
    } vst_t;

    vst_t          st_d, st_q;
    logic [VW-1:0] v_last;
    logic [PW-1:0] ph_n;

    always_comb begin
        st_d   = st_q;
        v_last = st_q.f ? V_LAST1 : V_LAST0;
        act    = (st_q.v >= V_TOP) && (st_q.v < V_END);
        ph_n   = (st_q.ph == PH_MAX) ? '0 : st_q.ph + 1'b1;

        if (line_end) begin
            if (st_q.v == v_last) begin
                st_d.v   = '0;
                st_d.f   = ~st_q.f;
                st_d.src = '0;
                st_d.ph  = '0;
            end else begin
                st_d.v = st_q.v + 1'b1;
                if (act) begin
                    st_d.ph = ph_n;
                    if (ph_n != PH_MAX) st_d.src = st_q.src + 1'b1;
                end
            end
        end

        fld = st_q.f;
        src = st_q.src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (src < SRC_LIM)); // R8

    AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act && st_q.ph == PH_MAX) |-> (src == $past(src))); // R8

    AST_F_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && st_q.v == v_last) |=> (fld != $past(fld))); // R5

endmodule

// File: rtl/vfmt_bytegen.sv
module vfmt_bytegen
    import vfmt_pkg::*;
#(
    parameter  int LINE_BYTES = 1728,
    parameter  int ACT_BYTES  = 1440,
    localparam int HW         = $clog2(LINE_BYTES),
    localparam int AW         = $clog2(ACT_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h,
    input  seg_e          seg,
    input  logic [1:0]    idx,
    input  logic          act,
    input  logic          fld,
    input  logic [7:0]    rd_data,
    output logic [7:0]    byte_o,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          line_start
);

    localparam logic [HW-1:0] RD_FIRST = HW'(LINE_BYTES - ACT_BYTES - 1);
    localparam logic [HW-1:0] RD_LAST  = HW'(LINE_BYTES - 2);

    typedef struct packed {
        logic [7:0] b;
    } bst_t;

    bst_t       st_d, st_q;
    logic [7:0] fill;
    logic [7:0] code;

    always_comb begin
        st_d = st_q;
        fill = h[0] ? FILL_LUMA : FILL_CHROMA;
        case (idx)
            2'd0:    code = TRS_FF;
            2'd1:    code = TRS_00;
            2'd2:    code = TRS_00;
            default: code = trs_word(fld, ~act, seg == SEG_EAV);
        endcase

        case (seg)
            SEG_EAV, SEG_SAV: st_d.b = code;
            SEG_HBLK:         st_d.b = fill;
            default:          st_d.b = act ? rd_data : fill;
        endcase

        rd_en      = act && (h >= RD_FIRST) && (h <= RD_LAST);
        rd_addr    = rd_en ? AW'(h - RD_FIRST) : '0;
        line_start = act && (h == '0);
        byte_o     = st_q.b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{b: FILL_LUMA};
        else        st_q <= st_d;
    end

    AST_LS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> !rd_en); // R9

    AST_ACT_FROM_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en, 2) |-> (byte_o == $past(rd_data))); // R7

endmodule

// File: rtl/vfmt_bt656_formatter.sv
module vfmt_bt656_formatter
    import vfmt_pkg::*;
#(
    parameter  int LINE_BYTES   = 1728,
    parameter  int ACT_PIX      = 720,
    parameter  int SRC_LINES    = 240,
    parameter  int REP          = 5,
    parameter  int VB_TOP       = 22,
    parameter  int FIELD0_LINES = 313,
    parameter  int FIELD1_LINES = 312,
    localparam int ACT_BYTES    = 2 * ACT_PIX,
    localparam int HW           = $clog2(LINE_BYTES),
    localparam int AW           = $clog2(ACT_BYTES),
    localparam int SW           = $clog2(SRC_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    rd_data,
    output logic [7:0]    bt_byte,
    output logic          line_start,
    output logic [SW-1:0] src_line,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr
);

    logic [HW-1:0] h;
    logic          line_end;
    seg_e          seg;
    logic [1:0]    idx;
    logic          act;
    logic          fld;

    vfmt_hpos #(
        .LINE_BYTES (LINE_BYTES),
        .ACT_BYTES  (ACT_BYTES)
    ) u_hpos (
        .clk      (clk),
        .rst_n    (rst_n),
        .h        (h),
        .line_end (line_end),
        .seg      (seg),
        .idx      (idx)
    );

    vfmt_vpos #(
        .SRC_LINES    (SRC_LINES),
        .REP          (REP),
        .VB_TOP       (VB_TOP),
        .FIELD0_LINES (FIELD0_LINES),
        .FIELD1_LINES (FIELD1_LINES)
    ) u_vpos (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_end (line_end),
        .act      (act),
        .fld      (fld),
        .src      (src_line)
    );

    vfmt_bytegen #(
        .LINE_BYTES (LINE_BYTES),
        .ACT_BYTES  (ACT_BYTES)
    ) u_bytegen (
        .clk        (clk),
        .rst_n      (rst_n),
        .h          (h),
        .seg        (seg),
        .idx        (idx),
        .act        (act),
        .fld        (fld),
        .rd_data    (rd_data),
        .byte_o     (bt_byte),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .line_start (line_start)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!line_start && !rd_en)); // R1

endmodule

// File: tb/tb_vfmt_bt656_formatter.sv
module tb_vfmt_bt656_formatter;

    localparam int LB   = 32;
    localparam int PIX  = 8;
    localparam int SRCN = 10;
    localparam int REP  = 5;
    localparam int VBT  = 2;
    localparam int F0   = 17;
    localparam int F1   = 16;
    localparam int ACTB = 2 * PIX;
    localparam int ACTS = LB - ACTB;
    localparam int SAVS = ACTS - 4;
    localparam int ACTL = SRCN * (REP + 1) / REP;
    localparam int SW   = $clog2(SRCN + 1);
    localparam int AW   = $clog2(ACTB);

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    rd_data = 8'h00;
    logic [7:0]    bt_byte;
    logic          line_start;
    logic [SW-1:0] src_line;
    logic          rd_en;
    logic [AW-1:0] rd_addr;

    always #10 clk = ~clk;

    vfmt_bt656_formatter #(
        .LINE_BYTES   (LB),
        .ACT_PIX      (PIX),
        .SRC_LINES    (SRCN),
        .REP          (REP),
        .VB_TOP       (VBT),
        .FIELD0_LINES (F0),
        .FIELD1_LINES (F1)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_data    (rd_data),
        .bt_byte    (bt_byte),
        .line_start (line_start),
        .src_line   (src_line),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr)
    );

    function automatic logic [7:0] buf_byte(int ln, int ad);
        return 8'(32 + ln * 16 + ad);
    endfunction

    // Line buffer model: one clock of read latency
    always @(posedge clk) if (rd_en) rd_data <= buf_byte(int'(src_line), int'(rd_addr));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int    nbad [8];
    int    fact [8];
    int    fexp [8];
    bit    used [8];
    string tags [8] = '{"R2 framing", "R3 XY protection", "R4 V flag", "R5 F flag",
                        "R6 blank fill", "R7 active data", "R9 strobes", "R8 repeat cadence"};

    function automatic int flen(int f);
        return f ? F1 : F0;
    endfunction

    function automatic bit is_act(int v);
        return (v >= VBT) && (v < VBT + ACTL);
    endfunction

    function automatic int src_of(int v);
        int a = v - VBT;
        int r = a % (REP + 1);
        return (a / (REP + 1)) * REP + ((r == REP) ? REP - 1 : r);
    endfunction

    function automatic logic [7:0] xy(bit f, bit v, bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] exp_byte(int f, int v, int h);
        logic [7:0] fill = (h % 2 != 0) ? 8'h10 : 8'h80;
        int k;
        if (h < 4 || (h >= SAVS && h < ACTS)) begin
            k = (h < 4) ? h : h - SAVS;
            if (k == 0) return 8'hFF;
            if (k < 3)  return 8'h00;
            return xy(f[0], !is_act(v), h < 4);
        end
        if (h < SAVS) return fill;
        return is_act(v) ? buf_byte(src_of(v), h - ACTS) : fill;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic note(int c, int a, int e);
        used[c] = 1'b1;
        if (a != e) begin
            if (nbad[c] == 0) begin
                fact[c] = a;
                fexp[c] = e;
            end
            nbad[c]++;
        end
    endtask

    task automatic check_line(int f, int v);
        for (int c = 0; c < 8; c++) begin
            nbad[c] = 0;
            used[c] = 1'b0;
        end
        for (int h = 0; h < LB; h++) begin
            logic [7:0] e;
            logic [7:0] a;
            int hn, vn, fn, eaddr;
            bit els, erd;
            @(negedge clk);
            e = exp_byte(f, v, h);
            a = bt_byte;
            if (h == 3 || h == SAVS + 3) begin
                note(1, int'({a[7], a[4:0]}), int'({e[7], e[4:0]}));
                note(2, int'(a[5]), int'(e[5]));
                note(3, int'(a[6]), int'(e[6]));
            end else if (h < 4 || (h >= SAVS && h < ACTS)) begin
                note(0, int'(a), int'(e));
            end else if (h >= ACTS && is_act(v)) begin
                note(5, int'(a), int'(e));
            end else begin
                note(4, int'(a), int'(e));
            end
            // strobes are decoded from the counter one position ahead
            hn = h + 1; vn = v; fn = f;
            if (hn == LB) begin
                hn = 0;
                vn = v + 1;
                if (vn == flen(f)) begin
                    vn = 0;
                    fn = 1 - f;
                end
            end
            els   = is_act(vn) && hn == 0;
            erd   = is_act(vn) && hn >= ACTS - 1 && hn <= LB - 2;
            eaddr = erd ? hn - (ACTS - 1) : 0;
            note(6, int'(line_start) * 512 + int'(rd_en) * 256 + int'(rd_addr),
                 int'(els) * 512 + int'(erd) * 256 + eaddr);
            if (els) note(7, int'(src_line), src_of(vn));
        end
        for (int c = 0; c < 8; c++)
            if (used[c])
                check(nbad[c] == 0, $sformatf("%s field=%0d line=%0d", tags[c], f, v),
                      fact[c], fexp[c]);
    endtask

    // R1: reset state, then release so the next edge emits stream position 0
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bt_byte == 8'h10, "R1 reset byte", int'(bt_byte), 8'h10);
        check(!line_start && !rd_en, "R1 reset strobes",
              int'(line_start) * 2 + int'(rd_en), 0);
        rst_n = 1'b1;
    endtask

    // R4 R5: one whole field, all lines, all bytes
    task automatic t_field(int f);
        for (int v = 0; v < flen(f); v++) check_line(f, v);
    endtask

    // R1: reset in the middle of a field restarts at line 0 with F=0
    task automatic t_midfield_reset();
        repeat (45) @(negedge clk);
        t_reset();
        t_field(0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_field(0);
        t_field(1);
        t_field(0);
        t_midfield_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule